// File: doc/BRIEF.md
# Conversion Queue Sequencer

This block walks a small memory of 8-bit conversion command words, one per step, starting at address 0 whenever a trigger arrives while it is idle. For each command it asks an external converter for one conversion over a request/done handshake. The request stays high, with the channel number held steady, until done is seen. The returned result is stored in a result table at the same index as the command. The next command is then taken up.

A queue ends in one of three ways. The command just before the boundary pointer (the first address of the following queue) completes. The command now under execution carries the reserved end-of-queue channel code, in which case no conversion is requested for it. Or the command at the last memory address completes. Each end sets a sticky completion flag and returns the sequencer to idle. A command with its pause bit set raises a sticky pause flag once its result is stored. In triggered mode the sequencer then holds until the next trigger. In software mode it carries on. Software clears either flag by reading the status while the flag is 1 and then writing 0 to it. The interrupt line follows the flags through per-flag enables.

Top module: `cmd_queue_seq`

## Requirements
- R1: After reset the state output is idle (0), both flags are 0, the interrupt output is 0 and no conversion is requested.
- R2: A trigger while idle starts at address 0. Each command requests a conversion of the channel in bits 5:0, the request being held until done. The result returned with done is stored in the result table at the command's address. Commands run in address order.
- R3: The queue ends, with the completion flag set and state idle, once the command at address boundary-1 completes. A boundary of 0 never ends a queue this way.
- R4: A command whose channel field is 63 ends the queue at once. It produces no conversion request, sets the completion flag and returns the sequencer to idle.
- R5: Completion of the command at address 39, the last one, ends the queue.
- R6: In triggered mode, after a command with bit 7 (pause) set completes, the pause flag is set and the state becomes paused (2). No request is made until the next trigger, after which execution resumes with the following command.
- R7: A pause command that is also the last command of its queue leaves the state idle, not paused, with both the pause and completion flags set.
- R8: In software mode a pause command sets the pause flag but the sequencer never enters the paused state.
- R9: The status write uses bit 0 for the completion flag and bit 1 for the pause flag. A flag clears only when 0 is written to it after a status read that saw it at 1. Any status write cancels that read. A write of 1, or a write of 0 without that read, leaves the flag set.
- R10: When a flag's set event and a valid clearing write meet in the same cycle, the flag stays set.
- R11: The interrupt output is high exactly when the completion flag is set with its enable, or the pause flag is set with its enable. The flags are maintained whatever the enables are.
- R12: A trigger that arrives while a queue is running does not restart or alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Trigger event: start when idle, resume when paused |
| sw_mode_i | input | 1 | 1 selects software (non-pausing) mode |
| bound_i | input | 6 | Boundary pointer: first address of the next queue |
| cmd_we_i | input | 1 | Command memory write enable |
| cmd_addr_i | input | 6 | Command memory write address |
| cmd_data_i | input | 8 | Command word: bit 7 pause, bits 5:0 channel |
| conv_req_o | output | 1 | Conversion request |
| conv_chan_o | output | 6 | Channel to convert |
| conv_done_i | input | 1 | Converter finished; result valid |
| conv_result_i | input | 10 | Conversion result |
| res_addr_i | input | 6 | Result table read address |
| res_data_o | output | 10 | Result table read data |
| stat_rd_i | input | 1 | Status read strobe |
| stat_wr_i | input | 1 | Status write strobe |
| stat_wdata_i | input | 2 | Status write data: bit 0 completion, bit 1 pause |
| done_flag_o | output | 1 | Completion flag |
| pause_flag_o | output | 1 | Pause flag |
| ie_done_i | input | 1 | Completion interrupt enable |
| ie_pause_i | input | 1 | Pause interrupt enable |
| irq_o | output | 1 | Interrupt request |
| state_o | output | 2 | 0 idle, 1 running, 2 paused |

## Verification
A corrupted command pointer shows at the converter port within one handshake: the next request carries the wrong channel, and a missed end of queue shows as surplus requests. A wrong state shows as a request during a pause, or as a missing one after a trigger, on the next cycle. A flag whose read-armed bit is wrong is exposed by the first clearing write, since it clears one write too early or stays set one write too long. A missing store is exposed by reading back the result table against the channels that were requested.

// File: rtl/cqs_pkg.sv
package cqs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } seq_state_e;
endpackage

// File: rtl/cqs_store.sv
module cqs_store #(
    parameter int W     = 8,
    parameter int DEPTH = 40,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [W-1:0]  rdata_o
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i && (waddr_i <= LAST)) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = (raddr_i <= LAST) ? mem_q[raddr_i] : '0;
endmodule

// File: rtl/cqs_flag.sv
module cqs_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
        logic armed;
    } fl_t;

    fl_t fl_q, fl_d;

    always_comb begin
        fl_d = fl_q;
        // a write always consumes an earlier read
        if (wr_i) begin
            fl_d.armed = 1'b0;
        end else if (rd_i && fl_q.flag) begin
            fl_d.armed = 1'b1;
        end
        // set takes priority over a clearing write
        if (set_i) begin
            fl_d.flag = 1'b1;
        end else if (wr_i && !wbit_i && fl_q.armed) begin
            fl_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign flag_o = fl_q.flag;

    // R9: a flag falls only after an armed write of 0
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_q.flag) |-> $past(wr_i && !wbit_i && fl_q.armed));

    // R10: a set event always leaves the flag high
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> fl_q.flag);
endmodule

// File: rtl/cmd_queue_seq.sv
module cmd_queue_seq
    import cqs_pkg::*;
#(
    parameter int DEPTH = 40,
    parameter int CMD_W = 8,
    parameter int CH_W  = 6,
    parameter int RES_W = 10,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic             sw_mode_i,
    input  logic [AW-1:0]    bound_i,
    input  logic             cmd_we_i,
    input  logic [AW-1:0]    cmd_addr_i,
    input  logic [CMD_W-1:0] cmd_data_i,
    output logic             conv_req_o,
    output logic [CH_W-1:0]  conv_chan_o,
    input  logic             conv_done_i,
    input  logic [RES_W-1:0] conv_result_i,
    input  logic [AW-1:0]    res_addr_i,
    output logic [RES_W-1:0] res_data_o,
    input  logic             stat_rd_i,
    input  logic             stat_wr_i,
    input  logic [1:0]       stat_wdata_i,
    output logic             done_flag_o,
    output logic             pause_flag_o,
    input  logic             ie_done_i,
    input  logic             ie_pause_i,
    output logic             irq_o,
    output logic [1:0]       state_o
);
    localparam logic [AW-1:0]   LAST_ADDR = AW'(DEPTH - 1);
    localparam logic [CH_W-1:0] EOQ_CODE  = '1;
    localparam int              PAUSE_BIT = CMD_W - 1;
    localparam int              N_FLAGS   = 2;

    typedef struct packed {
        seq_state_e    st;
        logic [AW-1:0] ptr;
    } core_t;

    core_t core_q, core_d;

    logic [CMD_W-1:0] cmd_word;
    logic [CH_W-1:0]  cmd_chan;
    logic             cmd_pause;
    logic             cmd_eoq;
    logic             at_last;
    logic [AW:0]      ptr_next;
    logic             res_we;
    logic             set_done;
    logic             set_pause;
    logic [N_FLAGS-1:0] set_vec;
    logic [N_FLAGS-1:0] flag_vec;

    cqs_store #(.W(CMD_W), .DEPTH(DEPTH)) u_cmd_mem (
        .clk     (clk),
        .we_i    (cmd_we_i),
        .waddr_i (cmd_addr_i),
        .wdata_i (cmd_data_i),
        .raddr_i (core_q.ptr),
        .rdata_o (cmd_word)
    );

    cqs_store #(.W(RES_W), .DEPTH(DEPTH)) u_res_mem (
        .clk     (clk),
        .we_i    (res_we),
        .waddr_i (core_q.ptr),
        .wdata_i (conv_result_i),
        .raddr_i (res_addr_i),
        .rdata_o (res_data_o)
    );

    assign cmd_chan  = cmd_word[CH_W-1:0];
    assign cmd_pause = cmd_word[PAUSE_BIT];
    assign cmd_eoq   = (cmd_chan == EOQ_CODE);
    assign ptr_next  = {1'b0, core_q.ptr} + (AW+1)'(1);
    assign at_last   = (core_q.ptr == LAST_ADDR) || (ptr_next == {1'b0, bound_i});

    always_comb begin
        core_d    = core_q;
        res_we    = 1'b0;
        set_done  = 1'b0;
        set_pause = 1'b0;
        unique case (core_q.st)
            ST_IDLE: begin
                if (trig_i) begin
                    core_d.ptr = '0;
                    core_d.st  = ST_RUN;
                end
            end
            ST_RUN: begin
                if (cmd_eoq) begin
                    set_done  = 1'b1;
                    core_d.st = ST_IDLE;
                end else if (conv_done_i) begin
                    res_we    = 1'b1;
                    set_pause = cmd_pause;
                    if (at_last) begin
                        set_done  = 1'b1;
                        core_d.st = ST_IDLE;
                    end else begin
                        core_d.ptr = ptr_next[AW-1:0];
                        if (cmd_pause && !sw_mode_i) begin
                            core_d.st = ST_HOLD;
                        end
                    end
                end
            end
            ST_HOLD: begin
                if (trig_i) begin
                    core_d.st = ST_RUN;
                end
            end
            default: core_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '{st: ST_IDLE, ptr: '0};
        end else begin
            core_q <= core_d;
        end
    end

    assign set_vec = {set_pause, set_done};

    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
        cqs_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_vec[g]),
            .rd_i   (stat_rd_i),
            .wr_i   (stat_wr_i),
            .wbit_i (stat_wdata_i[g]),
            .flag_o (flag_vec[g])
        );
    end

    assign done_flag_o  = flag_vec[0];
    assign pause_flag_o = flag_vec[1];
    assign irq_o        = (flag_vec[0] && ie_done_i) || (flag_vec[1] && ie_pause_i);
    assign conv_req_o   = (core_q.st == ST_RUN) && !cmd_eoq;
    assign conv_chan_o  = cmd_chan;
    assign state_o      = core_q.st;

    // R2: request and channel held until done
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req_o && !conv_done_i && !cmd_we_i) |=> (conv_req_o && $stable(conv_chan_o)));

    // R3: completion only rises on the way back to idle
    p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag_o) |-> (core_q.st == ST_IDLE));

    // R5: pointer never leaves the memory
    p_ptr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.ptr <= LAST_ADDR);

    // R6: entering pause always shows the pause flag
    p_hold_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_q.st == ST_HOLD) |-> pause_flag_o);

    // R8: software mode never holds
    p_sw_nohold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.st == ST_RUN && sw_mode_i) |=> (core_q.st != ST_HOLD));
endmodule

// File: tb/tb_cmd_queue_seq.sv
module tb_cmd_queue_seq;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig = 1'b0, sw_mode = 1'b0;
    logic [5:0] bound = '0;
    logic       cmd_we = 1'b0;
    logic [5:0] cmd_addr = '0;
    logic [7:0] cmd_data = '0;
    logic       conv_req;
    logic [5:0] conv_chan;
    logic       conv_done = 1'b0;
    logic [9:0] conv_result = '0;
    logic [5:0] res_addr = '0;
    logic [9:0] res_data;
    logic       stat_rd = 1'b0, stat_wr = 1'b0;
    logic [1:0] stat_wdata = '0;
    logic       done_flag, pause_flag;
    logic       ie_done = 1'b0, ie_pause = 1'b0;
    logic       irq;
    logic [1:0] state;

    int total = 0;
    int bad = 0;
    int conv_count = 0;
    int chan_log [64];
    bit auto_conv = 1'b1;
    bit saw_hold = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_queue_seq dut (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .sw_mode_i(sw_mode),
        .bound_i(bound), .cmd_we_i(cmd_we), .cmd_addr_i(cmd_addr),
        .cmd_data_i(cmd_data), .conv_req_o(conv_req), .conv_chan_o(conv_chan),
        .conv_done_i(conv_done), .conv_result_i(conv_result),
        .res_addr_i(res_addr), .res_data_o(res_data), .stat_rd_i(stat_rd),
        .stat_wr_i(stat_wr), .stat_wdata_i(stat_wdata), .done_flag_o(done_flag),
        .pause_flag_o(pause_flag), .ie_done_i(ie_done), .ie_pause_i(ie_pause),
        .irq_o(irq), .state_o(state)
    );

    typedef struct packed {
        logic [6:0] bnd;
        logic [6:0] eoq_at;
        logic [6:0] exp_n;
    } vec_t;

    // eoq_at of 127 means no end-of-queue code in the memory
    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{bnd: 7'd5,  eoq_at: 7'd127, exp_n: 7'd5},
        '{bnd: 7'd12, eoq_at: 7'd3,   exp_n: 7'd3},
        '{bnd: 7'd0,  eoq_at: 7'd127, exp_n: 7'd40},
        '{bnd: 7'd20, eoq_at: 7'd0,   exp_n: 7'd0},
        '{bnd: 7'd1,  eoq_at: 7'd127, exp_n: 7'd1},
        '{bnd: 7'd40, eoq_at: 7'd39,  exp_n: 7'd39}
    };

    function automatic int chan_of(int i);
        return (i * 7 + 3) % 63;
    endfunction

    function automatic int res_of(int ch);
        return (ch * 13 + 1) % 1024;
    endfunction

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // converter model: done one cycle after a request is seen
    initial begin
        forever begin
            @(negedge clk);
            if (auto_conv) begin
                if (conv_req && !conv_done) begin
                    chan_log[conv_count % 64] = int'(conv_chan);
                    conv_count++;
                    conv_result = 10'(res_of(int'(conv_chan)));
                    conv_done = 1'b1;
                end else begin
                    conv_done = 1'b0;
                end
            end
        end
    end

    task automatic load_q(int eoq_at, logic [DEPTH-1:0] pmask);
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            cmd_we   = 1'b1;
            cmd_addr = 6'(i);
            cmd_data = {pmask[i], 1'b0, (i == eoq_at) ? 6'd63 : 6'(chan_of(i))};
        end
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic pulse_trig();
        @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic st_read();
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic st_write(logic [1:0] v);
        @(negedge clk);
        stat_wr = 1'b1;
        stat_wdata = v;
        @(negedge clk);
        stat_wr = 1'b0;
    endtask

    task automatic clear_all();
        st_read();
        st_write(2'b00);
    endtask

    task automatic wait_state(logic [1:0] want);
        for (int k = 0; k < 3000; k++) begin
            if (state == 2'd2) saw_hold = 1'b1;
            if (state == want) break;
            @(negedge clk);
        end
    endtask

    task automatic run_start();
        conv_count = 0;
        saw_hold = 1'b0;
        pulse_trig();
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired act=1 exp=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 state", int'(state), 0);
        chk("R1 done flag", int'(done_flag), 0);
        chk("R1 pause flag", int'(pause_flag), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 req", int'(conv_req), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // vector walk: R2, R3, R4, R5
        for (int v = 0; v < NV; v++) begin
            string tag;
            tag = (VECS[v].eoq_at != 7'd127) ? "R4" : (VECS[v].bnd == 7'd0) ? "R5" : "R3";
            load_q(int'(VECS[v].eoq_at), '0);
            bound = VECS[v].bnd[5:0];
            run_start();
            wait_state(2'd0);
            repeat (2) @(negedge clk);
            chk({tag, " conversions"}, conv_count, int'(VECS[v].exp_n));
            chk({tag, " done flag"}, int'(done_flag), 1);
            chk({tag, " idle"}, int'(state), 0);
            for (int i = 0; i < int'(VECS[v].exp_n); i++) begin
                res_addr = 6'(i);
                #1;
                chk("R2 channel order", chan_log[i], chan_of(i));
                chk("R2 stored result", int'(res_data), res_of(chan_of(i)));
            end
            if (v == 0) begin
                // R11: enables gate the interrupt, flag polled regardless
                ie_done = 1'b1;
                #1 chk("R11 irq with enable", int'(irq), 1);
                ie_done = 1'b0;
                #1 chk("R11 irq masked", int'(irq), 0);
                chk("R11 flag kept while masked", int'(done_flag), 1);
                // R9: clear handshake
                st_write(2'b00);
                chk("R9 write 0 without read", int'(done_flag), 1);
                st_read();
                st_write(2'b01);
                chk("R9 write 1 after read", int'(done_flag), 1);
                st_write(2'b00);
                chk("R9 write 0 after disarm", int'(done_flag), 1);
                st_read();
                st_write(2'b00);
                chk("R9 read then write 0", int'(done_flag), 0);
            end
            clear_all();
        end

        // R6 and R12: pause in triggered mode, trigger while running
        load_q(127, 40'h4);
        bound = 6'd6;
        run_start();
        wait_state(2'd2);
        chk("R6 paused state", int'(state), 2);
        chk("R6 pause flag", int'(pause_flag), 1);
        chk("R6 no completion yet", int'(done_flag), 0);
        chk("R6 count at pause", conv_count, 3);
        ie_pause = 1'b1;
        #1 chk("R11 irq from pause", int'(irq), 1);
        ie_pause = 1'b0;
        repeat (8) @(negedge clk);
        chk("R6 no request while paused", int'(conv_req), 0);
        chk("R6 count held", conv_count, 3);
        pulse_trig();
        pulse_trig();
        wait_state(2'd0);
        repeat (2) @(negedge clk);
        chk("R12 count after stray trigger", conv_count, 6);
        chk("R6 resumed order", chan_log[3], chan_of(3));
        chk("R6 done after resume", int'(done_flag), 1);
        clear_all();

        // R7: pause on last command
        load_q(127, 40'h8);
        bound = 6'd4;
        run_start();
        wait_state(2'd0);
        repeat (2) @(negedge clk);
        chk("R7 count", conv_count, 4);
        chk("R7 never paused", int'(saw_hold), 0);
        chk("R7 pause flag", int'(pause_flag), 1);
        chk("R7 done flag", int'(done_flag), 1);
        chk("R7 idle", int'(state), 0);
        clear_all();

        // R8: software mode does not hold
        sw_mode = 1'b1;
        load_q(127, 40'h2);
        bound = 6'd4;
        run_start();
        wait_state(2'd0);
        repeat (2) @(negedge clk);
        chk("R8 count", conv_count, 4);
        chk("R8 never paused", int'(saw_hold), 0);
        chk("R8 pause flag", int'(pause_flag), 1);
        chk("R8 done flag", int'(done_flag), 1);
        clear_all();
        chk("R9 both cleared", int'({pause_flag, done_flag}), 0);

        // R10: set and clear in the same cycle
        auto_conv = 1'b0;
        load_q(127, 40'h3);
        bound = 6'd3;
        run_start();
        @(negedge clk);
        chk("R10 request up", int'(conv_req), 1);
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        chk("R10 first pause flag", int'(pause_flag), 1);
        st_read();
        @(negedge clk);
        conv_done = 1'b1;
        stat_wr = 1'b1;
        stat_wdata = 2'b00;
        @(negedge clk);
        conv_done = 1'b0;
        stat_wr = 1'b0;
        chk("R10 set beats clear", int'(pause_flag), 1);
        auto_conv = 1'b1;
        wait_state(2'd0);
        repeat (2) @(negedge clk);
        chk("R10 run finished", int'(done_flag), 1);
        clear_all();
        chk("R9 pause cleared after handshake", int'(pause_flag), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule